// File: doc/BRIEF.md
# AC'97 Codec Command Slot Decoder

This block sits between an AC'97 link deserializer and a codec register file. Once per frame the deserializer presents three parallel words from the controller: the 16-bit tag slot, the 20-bit command-address slot and the 20-bit command-data slot. It marks them with a single-cycle `frame_stb`.

The decoder decides whether the frame carries a register read or a register write aimed at this codec. In primary mode the address-valid and data-valid tag bits select the command. In secondary mode a nonzero codec ID in the tag slot that equals the configured ID selects it instead, and the read/write flag in slot 1 chooses between read and write.

Accepted commands become one-cycle strobes towards the register file. The decoder then assembles the status tag, status-address and status-data words that the serializer returns in the following frame. Serial shifting, SYNC generation and the register storage itself are outside this block.

Top module: `ac97_cmd_decoder`

## Requirements
- R1: A frame whose tag bit 15 (frame valid) is 0 produces no read or write strobe, whatever its other tag bits and codec ID bits (tag bits 1..0) hold.
- R2: In primary mode (`sec_mode`=0), tag bits 15/14/13 = 1/1/0 with ID bits 00 produce `rf_rd_en` for exactly one cycle, in the cycle after `frame_stb`. `rf_addr` carries slot 1 bits 18..12. The slot 1 read/write bit is not consulted.
- R3: In primary mode, tag bits 15/14/13 = 1/1/1 with ID bits 00 produce `rf_wr_en` for exactly one cycle, in the cycle after `frame_stb`. `rf_addr` carries slot 1 bits 18..12 and `rf_wdata` carries slot 2 bits 19..4.
- R4: In primary mode, a frame whose ID bits are nonzero produces no strobe.
- R5: In secondary mode, tag bits 14 and 13 are ignored. A valid frame whose nonzero ID equals `cfg_id` is accepted. Slot 1 bit 19 = 1 makes it a read and 0 makes it a write, with the same address and data fields and strobe timing as R2/R3.
- R6: In secondary mode, a frame with ID bits 00, or with ID bits that differ from `cfg_id`, produces no strobe.
- R7: After an accepted read, the status words change two cycles after `frame_stb` and then hold:
  - `in_tag` has bit 15 equal to `codec_ready` as sampled with `frame_stb`, bits 14 and 13 set, and all other bits 0.
  - `in_slot1` holds the register index in bits 18..12 and 0 elsewhere.
  - `in_slot2` holds the read data in bits 19..4 and 0 in bits 3..0.
- R8: After any frame without an accepted read, the status words change two cycles after `frame_stb`. `in_tag` has bit 15 equal to the sampled `codec_ready` and all other bits 0, and `in_slot1` and `in_slot2` are 0.
- R9: Strobes appear only in the cycle after `frame_stb`. `rf_addr` and `rf_wdata` change only on an accepted command. The status words change only two cycles after `frame_stb`.
- R10: Synchronous active-high reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle marker: slot words are valid |
| out_tag | input | 16 | Controller tag slot |
| out_slot1 | input | 20 | Controller command-address slot |
| out_slot2 | input | 20 | Controller command-data slot |
| sec_mode | input | 1 | 1 = secondary codec, 0 = primary |
| cfg_id | input | 2 | Configured secondary codec ID |
| codec_ready | input | 1 | Drives frame-valid bit of the status tag |
| rf_rdata | input | 16 | Register file read data, valid while `rf_rd_en` is high |
| rf_rd_en | output | 1 | Register read strobe |
| rf_wr_en | output | 1 | Register write strobe |
| rf_addr | output | 7 | Register index |
| rf_wdata | output | 16 | Register write data |
| in_tag | output | 16 | Status tag for the next frame |
| in_slot1 | output | 20 | Status-address word |
| in_slot2 | output | 20 | Status-data word |

## Verification
The bench uses the package defaults: a 7-bit index, 16-bit data and 20-bit slots. With these, every register index and every tag pattern, including all four ID values, can be reached. The bench drives both modes with every configured ID, mixes directed tag patterns with random frames, and keeps a register-file model, so writes followed by reads show that addresses and data reach the status words intact.

// File: rtl/ac97cmd_pkg.sv
package ac97cmd_pkg;

    localparam int TAG_W   = 16;
    localparam int SLOT_W  = 20;
    localparam int IDX_W   = 7;
    localparam int DAT_W   = 16;
    localparam int ID_W    = 2;

    localparam int TAG_FRAME = TAG_W - 1;
    localparam int TAG_ADDR  = TAG_W - 2;
    localparam int TAG_DATA  = TAG_W - 3;
    localparam int RW_BIT    = SLOT_W - 1;
    localparam int IDX_LSB   = SLOT_W - 1 - IDX_W;
    localparam int DAT_LSB   = SLOT_W - DAT_W;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [IDX_W-1:0]   idx;
        logic [DAT_W-1:0]   wdata;
    } cmd_t;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [SLOT_W-1:0]  addr_word;
        logic [SLOT_W-1:0]  data_word;
    } resp_t;

    function automatic logic [SLOT_W-1:0] place_idx(input logic [IDX_W-1:0] idx);
        logic [SLOT_W-1:0] w;
        w = '0;
        w[IDX_LSB +: IDX_W] = idx;
        return w;
    endfunction

    function automatic logic [SLOT_W-1:0] place_data(input logic [DAT_W-1:0] d);
        logic [SLOT_W-1:0] w;
        w = '0;
        w[DAT_LSB +: DAT_W] = d;
        return w;
    endfunction

endpackage

// File: rtl/ac97_cmd_qualify.sv
module ac97_cmd_qualify
    import ac97cmd_pkg::*;
(
    input  logic [TAG_W-1:0]  tag,
    input  logic [SLOT_W-1:0] slot1,
    input  logic [SLOT_W-1:0] slot2,
    input  logic              sec_mode,
    input  logic [ID_W-1:0]   cfg_id,
    output cmd_t              cmd
);

    logic [ID_W-1:0] frame_id;
    logic            prim_ok;
    logic            sec_ok;

    assign frame_id = tag[ID_W-1:0];
    assign prim_ok  = tag[TAG_FRAME] && !sec_mode && (frame_id == '0) && tag[TAG_ADDR];
    assign sec_ok   = tag[TAG_FRAME] && sec_mode && (frame_id != '0) && (frame_id == cfg_id);

    always_comb begin
        cmd.kind  = CMD_NONE;
        cmd.idx   = slot1[IDX_LSB +: IDX_W];
        cmd.wdata = slot2[DAT_LSB +: DAT_W];
        if (prim_ok) begin
            cmd.kind = tag[TAG_DATA] ? CMD_WRITE : CMD_READ;
        end else if (sec_ok) begin
            cmd.kind = slot1[RW_BIT] ? CMD_READ : CMD_WRITE;
        end
    end

endmodule

// File: rtl/ac97_cmd_issue.sv
module ac97_cmd_issue
    import ac97cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  cmd_t             cmd,
    input  logic             codec_ready,
    output logic             rd_en,
    output logic             wr_en,
    output logic [IDX_W-1:0] addr,
    output logic [DAT_W-1:0] wdata,
    output logic             resp_stb,
    output logic             ready_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en    <= 1'b0;
            wr_en    <= 1'b0;
            addr     <= '0;
            wdata    <= '0;
            resp_stb <= 1'b0;
            ready_q  <= 1'b0;
        end else begin
            rd_en    <= frame_stb && (cmd.kind == CMD_READ);
            wr_en    <= frame_stb && (cmd.kind == CMD_WRITE);
            resp_stb <= frame_stb;
            if (frame_stb) begin
                ready_q <= codec_ready;
            end
            if (frame_stb && cmd.kind != CMD_NONE) begin
                addr <= cmd.idx;
            end
            if (frame_stb && cmd.kind == CMD_WRITE) begin
                wdata <= cmd.wdata;
            end
        end
    end

    // R9
    strobe_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> $past(frame_stb));

    // R9
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> !(rd_en && wr_en));

endmodule

// File: rtl/ac97_resp_build.sv
module ac97_resp_build
    import ac97cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             resp_stb,
    input  logic             rd_en,
    input  logic             ready_q,
    input  logic [IDX_W-1:0] addr,
    input  logic [DAT_W-1:0] rdata,
    output resp_t            resp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else if (resp_stb) begin
            resp.tag            <= '0;
            resp.tag[TAG_FRAME] <= ready_q;
            resp.tag[TAG_ADDR]  <= rd_en;
            resp.tag[TAG_DATA]  <= rd_en;
            resp.addr_word      <= rd_en ? place_idx(addr) : '0;
            resp.data_word      <= rd_en ? place_data(rdata) : '0;
        end
    end

    // R7
    read_resp_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_stb && rd_en) |=> (resp.tag[TAG_ADDR] && resp.tag[TAG_DATA] && resp.tag[ID_W-1:0] == '0));

    // R8
    idle_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_stb && !rd_en) |=> (!resp.tag[TAG_ADDR] && !resp.tag[TAG_DATA] && resp.addr_word == '0));

    // R9
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !resp_stb |=> $stable(resp));

endmodule

// File: rtl/ac97_cmd_decoder.sv
module ac97_cmd_decoder
    import ac97cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [TAG_W-1:0]  out_tag,
    input  logic [SLOT_W-1:0] out_slot1,
    input  logic [SLOT_W-1:0] out_slot2,
    input  logic              sec_mode,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              codec_ready,
    input  logic [DAT_W-1:0]  rf_rdata,
    output logic              rf_rd_en,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_addr,
    output logic [DAT_W-1:0]  rf_wdata,
    output logic [TAG_W-1:0]  in_tag,
    output logic [SLOT_W-1:0] in_slot1,
    output logic [SLOT_W-1:0] in_slot2
);

    cmd_t  cmd;
    resp_t resp;
    logic  resp_stb;
    logic  ready_q;

    ac97_cmd_qualify u_qual (
        .tag      (out_tag),
        .slot1    (out_slot1),
        .slot2    (out_slot2),
        .sec_mode (sec_mode),
        .cfg_id   (cfg_id),
        .cmd      (cmd)
    );

    ac97_cmd_issue u_issue (
        .clk         (clk),
        .rst         (rst),
        .frame_stb   (frame_stb),
        .cmd         (cmd),
        .codec_ready (codec_ready),
        .rd_en       (rf_rd_en),
        .wr_en       (rf_wr_en),
        .addr        (rf_addr),
        .wdata       (rf_wdata),
        .resp_stb    (resp_stb),
        .ready_q     (ready_q)
    );

    ac97_resp_build u_resp (
        .clk      (clk),
        .rst      (rst),
        .resp_stb (resp_stb),
        .rd_en    (rf_rd_en),
        .ready_q  (ready_q),
        .addr     (rf_addr),
        .rdata    (rf_rdata),
        .resp     (resp)
    );

    assign in_tag   = resp.tag;
    assign in_slot1 = resp.addr_word;
    assign in_slot2 = resp.data_word;

    // R1
    invalid_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !out_tag[TAG_FRAME]) |=> (!rf_rd_en && !rf_wr_en));

    // R4
    primary_id_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !sec_mode && out_tag[ID_W-1:0] != '0) |=> (!rf_rd_en && !rf_wr_en));

    // R6
    secondary_id_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && sec_mode && (out_tag[ID_W-1:0] == '0 || out_tag[ID_W-1:0] != cfg_id))
        |=> (!rf_rd_en && !rf_wr_en));

endmodule

// File: tb/ac97_cmd_decoder_tb.sv
module ac97_cmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic [15:0] out_tag = '0;
    logic [19:0] out_slot1 = '0;
    logic [19:0] out_slot2 = '0;
    logic        sec_mode = 1'b0;
    logic [1:0]  cfg_id = 2'd0;
    logic        codec_ready = 1'b1;
    logic [15:0] rf_rdata;
    logic        rf_rd_en, rf_wr_en;
    logic [6:0]  rf_addr;
    logic [15:0] rf_wdata;
    logic [15:0] in_tag;
    logic [19:0] in_slot1, in_slot2;

    always #10 clk = ~clk;

    ac97_cmd_decoder u_dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .out_tag(out_tag),
        .out_slot1(out_slot1), .out_slot2(out_slot2), .sec_mode(sec_mode),
        .cfg_id(cfg_id), .codec_ready(codec_ready), .rf_rdata(rf_rdata),
        .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .in_tag(in_tag), .in_slot1(in_slot1), .in_slot2(in_slot2)
    );

    // register file model driven by the DUT strobes
    logic [15:0] mem [128];
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    end
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) if (rf_wr_en) mem[rf_addr] <= rf_wdata;

    // behavioural reference
    logic        e_rd, e_wr, e_ready, e_rstb;
    logic [6:0]  e_addr;
    logic [15:0] e_wdata;
    logic [15:0] e_tag;
    logic [19:0] e_s1, e_s2;
    string       cur_req = "R10";
    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always @(posedge clk) begin
        bit acc_r, acc_w;
        if (rst) begin
            e_rd = 0; e_wr = 0; e_ready = 0; e_rstb = 0;
            e_addr = 0; e_wdata = 0; e_tag = 0; e_s1 = 0; e_s2 = 0;
        end else begin
            if (e_rstb) begin
                e_tag = {e_ready, e_rd, e_rd, 13'd0};
                e_s1  = e_rd ? {1'b0, e_addr, 12'd0} : 20'd0;
                e_s2  = e_rd ? {mem[e_addr], 4'd0} : 20'd0;
            end
            acc_r = 0; acc_w = 0;
            if (frame_stb && out_tag[15]) begin
                if (!sec_mode) begin
                    if (out_tag[1:0] == 2'd0 && out_tag[14]) begin
                        acc_r = !out_tag[13];
                        acc_w = out_tag[13];
                    end
                end else if (out_tag[1:0] != 2'd0 && out_tag[1:0] == cfg_id) begin
                    acc_r = out_slot1[19];
                    acc_w = !out_slot1[19];
                end
            end
            e_rd = acc_r;
            e_wr = acc_w;
            e_rstb = frame_stb;
            if (frame_stb) e_ready = codec_ready;
            if (acc_r || acc_w) e_addr = out_slot1[18:12];
            if (acc_w) e_wdata = out_slot2[19:4];
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        chk("rd_en",  32'(rf_rd_en), 32'(e_rd));
        chk("wr_en",  32'(rf_wr_en), 32'(e_wr));
        chk("addr",   32'(rf_addr),  32'(e_addr));
        chk("wdata",  32'(rf_wdata), 32'(e_wdata));
        chk("in_tag", 32'(in_tag),   32'(e_tag));
        chk("in_s1",  32'(in_slot1), 32'(e_s1));
        chk("in_s2",  32'(in_slot2), 32'(e_s2));
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic frame(input logic [15:0] t, input logic [19:0] s1, input logic [19:0] s2);
        @(negedge clk);
        out_tag = t; out_slot1 = s1; out_slot2 = s2; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 primary read
        cur_req = "R2";
        frame(16'hC000, {1'b0, 7'h15, 12'hABC}, 20'h0);
        // R3 primary write then R7 read-back
        cur_req = "R3";
        frame(16'hE000, {1'b1, 7'h15, 12'h123}, {16'hBEEF, 4'hF});
        cur_req = "R7";
        frame(16'hC000, {1'b0, 7'h15, 12'h0}, 20'h0);
        // R1 frame-valid low
        cur_req = "R1";
        frame(16'h6000, {1'b0, 7'h01, 12'h0}, {16'h1111, 4'h0});
        frame(16'h4000, {1'b1, 7'h02, 12'h0}, 20'h0);
        // R4 primary with nonzero ID
        cur_req = "R4";
        frame(16'hE001, {1'b0, 7'h03, 12'h0}, {16'h2222, 4'h0});
        frame(16'hC002, {1'b1, 7'h03, 12'h0}, 20'h0);
        // R5 secondary, ID 2, tag 14/13 both states
        sec_mode = 1'b1; cfg_id = 2'd2;
        cur_req = "R5";
        frame(16'h8002, {1'b0, 7'h7F, 12'hFFF}, {16'hCAFE, 4'h5});
        frame(16'h8002, {1'b1, 7'h7F, 12'h0}, 20'h0);
        frame(16'hE002, {1'b1, 7'h00, 12'h0}, 20'h0);
        frame(16'hC002, {1'b0, 7'h00, 12'h0}, {16'h0F0F, 4'h0});
        // R1 secondary with matching ID but invalid frame
        cur_req = "R1";
        frame(16'h0002, {1'b0, 7'h10, 12'h0}, {16'h9999, 4'h0});
        // R6 secondary ID mismatch / zero
        cur_req = "R6";
        frame(16'hE000, {1'b0, 7'h11, 12'h0}, {16'h3333, 4'h0});
        frame(16'h8001, {1'b0, 7'h11, 12'h0}, {16'h4444, 4'h0});
        frame(16'h8003, {1'b1, 7'h11, 12'h0}, 20'h0);
        cfg_id = 2'd0;
        frame(16'h8000, {1'b0, 7'h12, 12'h0}, {16'h5555, 4'h0});
        // R8 codec not ready
        cur_req = "R8";
        codec_ready = 1'b0;
        cfg_id = 2'd1;
        frame(16'h8001, {1'b1, 7'h7F, 12'h0}, 20'h0);
        frame(16'h8003, {1'b1, 7'h7F, 12'h0}, 20'h0);
        codec_ready = 1'b1;
        frame(16'h0000, 20'h0, 20'h0);
        // R9 random frames, back to back at times
        cur_req = "R9";
        for (int k = 0; k < 400; k++) begin
            sec_mode = 1'($urandom);
            cfg_id   = 2'($urandom);
            codec_ready = 1'($urandom);
            @(negedge clk);
            out_tag = 16'($urandom) | 16'h8000 * 16'($urandom_range(0, 1));
            out_tag[1:0] = 2'($urandom);
            out_slot1 = 20'($urandom);
            out_slot2 = 20'($urandom);
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule